// File: doc/BRIEF.md
# Sector ECC Status Scanner

After a page has been read from flash and run through the BCH decoder, the decoder leaves one result byte for each sector. Four of these bytes are packed into each 32-bit status word. This block walks those status words through a one-cycle-latency read port. It works out what the page read means for software. Did any sector fail beyond repair? How many bits were corrected in total? What was the worst single sector? For every sector that can be repaired, it sends a request to the downstream correction engine. Each request carries the sector index and the number of flipped bits.

A scan starts with a one-cycle `start` pulse. The page size code and the sector size select are sampled on that same cycle. They set the number of status words that are read. The scan skips status words that are entirely zero. It stops at the first sector that cannot be repaired. It ends with a one-cycle `done` pulse. All summary outputs keep their values until the next accepted start. The count of unrepairable events carries on from scan to scan until reset.

Top module: `ecc_status_scanner`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `fix_valid` and `rd_en` are 0, and `total_bits`, `max_bits` and `uncorr_count` are 0.
- R2: The sector count is the page size divided by the sector size. The page size is 2 KiB for `page_sel`=00, 4 KiB for 01, and 8 KiB for 1x. The sector size is 512 bytes, or 1024 bytes when `sect_1k`=1. The scan reads status words at addresses 0, 1, 2, … in ascending order. It reads max(1, sectors/4) words at most, and never reads an address beyond that.
- R3: A status word equal to zero produces no fix request and does not change `total_bits`, `max_bits` or `fail`.
- R4: Sector index 4·j+i is reported for byte i (bits 8i+7:8i) of status word j. Fix requests come out in ascending sector order.
- R5: A non-zero byte whose bits 1:0 are 01 is correctable. It produces exactly one `fix_valid` pulse carrying its sector index and its count, taken from bits 6:2.
- R6: At `done`, `total_bits` is the sum of the counts of all correctable sectors scanned, and `max_bits` is the largest of them. Both are 0 when there are none.
- R7: A non-zero byte whose bits 1:0 are not 01 is unrepairable. It sets `fail` and adds 1 to `uncorr_count`, which saturates. It then ends the scan: no later byte is examined and no further word is read.
- R8: A zero byte inside a non-zero status word counts as error-free.
- R9: A `start` is accepted only while `busy` is 0. `done` is a single-cycle pulse. `fail`, `total_bits` and `max_bits` hold until the next accepted start, which clears them.
- R10: Bit 7 of a status byte never enters the count. A byte whose bits 1:0 are 00 but whose other bits are non-zero is unrepairable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| page_sel | input | 2 | Page size code: 00 = 2 KiB, 01 = 4 KiB, 1x = 8 KiB |
| sect_1k | input | 1 | 1 = 1024-byte sectors, 0 = 512-byte sectors |
| rd_en | output | 1 | Status word read request |
| rd_addr | output | 2 | Status word index |
| rd_data | input | 32 | Status word, valid the cycle after the request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| fail | output | 1 | An unrepairable sector was found |
| total_bits | output | 9 | Sum of corrected bit counts |
| max_bits | output | 5 | Largest per-sector corrected count |
| uncorr_count | output | 8 | Saturating count of unrepairable events since reset |
| fix_valid | output | 1 | Correction request strobe |
| fix_sector | output | 4 | Sector index of the request |
| fix_count | output | 5 | Bit-error count of the request |

## Verification
A wrong word counter or page-size decode shows up as a read count or address that differs from the expected one. It also shows up as fix requests that are missing or extra. Both are visible before `done`. A wrong lane counter or lane mux shows as a wrong sector index or count on the very next `fix_valid` pulse. An accumulator that fails to clear or to stop shows as wrong `total_bits` or `max_bits` at `done`. So does a missed abort, which additionally produces fix requests after `fail`. Corruption of the unrepairable counter shows up at the end of the scan that caused it, and stays visible in every scan after it.

// File: rtl/ecc_scan_pkg.sv
package ecc_scan_pkg;

  // Classification of one sector result byte
  typedef enum logic [1:0] {
    LANE_CLEAN = 2'd0,
    LANE_FIX   = 2'd1,
    LANE_FAIL  = 2'd2
  } lane_kind_e;

  // Scan sequencer states
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_LATCH = 3'd2,
    S_SCAN  = 3'd3,
    S_FIN   = 3'd4
  } scan_state_e;

endpackage

// File: rtl/ecc_lane_decode.sv
module ecc_lane_decode
  import ecc_scan_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic [LANE_W-1:0] lane_byte,
  output lane_kind_e        kind,
  output logic [CNT_W-1:0]  cnt
);
  localparam int VERD_W = 2;
  localparam logic [VERD_W-1:0] VERD_FIXABLE = 2'b01;

  always_comb begin
    cnt = lane_byte[VERD_W +: CNT_W];
    if (lane_byte == '0)
      kind = LANE_CLEAN;
    else if (lane_byte[VERD_W-1:0] == VERD_FIXABLE)
      kind = LANE_FIX;
    else
      kind = LANE_FAIL;
  end
endmodule

// File: rtl/ecc_scan_seq.sv
module ecc_scan_seq
  import ecc_scan_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int LANES     = 4,
  parameter int LANE_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [ADDR_W:0]      n_words,
  input  logic                 word_zero,
  input  logic                 lane_fail,
  output logic                 busy,
  output logic                 clear,
  output logic                 rd_en,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic                 load_word,
  output logic                 eval_en,
  output logic [LANE_LOG2-1:0] lane,
  output logic                 done
);
  localparam int NW_W = ADDR_W + 1;
  localparam logic [LANE_LOG2-1:0] LAST_LANE = LANE_LOG2'(LANES - 1);

  scan_state_e          state_q;
  logic                 rd_en_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [NW_W-1:0]      nw_q;
  logic [LANE_LOG2-1:0] lane_q;
  logic                 done_q;
  logic                 last_word;

  assign last_word = (({1'b0, addr_q}) + NW_W'(1)) == nw_q;
  assign busy      = (state_q != S_IDLE);
  assign clear     = start && (state_q == S_IDLE);
  assign load_word = (state_q == S_LATCH) && !word_zero;
  assign eval_en   = (state_q == S_SCAN);
  assign rd_en     = rd_en_q;
  assign rd_addr   = addr_q;
  assign lane      = lane_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      rd_en_q <= 1'b0;
      addr_q  <= '0;
      nw_q    <= '0;
      lane_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      rd_en_q <= 1'b0;
      done_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            nw_q    <= n_words;
            addr_q  <= '0;
            rd_en_q <= 1'b1;
            state_q <= S_READ;
          end
        end
        S_READ: state_q <= S_LATCH;
        S_LATCH: begin
          if (!word_zero) begin
            lane_q  <= '0;
            state_q <= S_SCAN;
          end else if (last_word) begin
            state_q <= S_FIN;
          end else begin
            addr_q  <= addr_q + ADDR_W'(1);
            rd_en_q <= 1'b1;
            state_q <= S_READ;
          end
        end
        S_SCAN: begin
          if (lane_fail) begin
            state_q <= S_FIN;
          end else if (lane_q == LAST_LANE) begin
            if (last_word) begin
              state_q <= S_FIN;
            end else begin
              addr_q  <= addr_q + ADDR_W'(1);
              rd_en_q <= 1'b1;
              state_q <= S_READ;
            end
          end else begin
            lane_q <= lane_q + LANE_LOG2'(1);
          end
        end
        S_FIN: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_q |-> ({1'b0, addr_q} < nw_q));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(nw_q));

  // R7
  fail_stops_reads_chk: assert property (@(posedge clk) disable iff (rst)
    (eval_en && lane_fail) |=> !rd_en_q);
endmodule

// File: rtl/ecc_scan_accum.sv
module ecc_scan_accum
  import ecc_scan_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int SECT_W  = 4,
  parameter int TOTAL_W = 9,
  parameter int UCNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               eval_en,
  input  lane_kind_e         kind,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [SECT_W-1:0]  sector,
  output logic               fail,
  output logic [TOTAL_W-1:0] total,
  output logic [CNT_W-1:0]   maxc,
  output logic [UCNT_W-1:0]  ucnt,
  output logic               fix_valid,
  output logic [SECT_W-1:0]  fix_sector,
  output logic [CNT_W-1:0]   fix_count
);
  logic               fail_q;
  logic [TOTAL_W-1:0] total_q;
  logic [CNT_W-1:0]   max_q;
  logic [UCNT_W-1:0]  ucnt_q;
  logic               fixv_q;
  logic [SECT_W-1:0]  fixs_q;
  logic [CNT_W-1:0]   fixc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q  <= 1'b0;
      total_q <= '0;
      max_q   <= '0;
      ucnt_q  <= '0;
      fixv_q  <= 1'b0;
      fixs_q  <= '0;
      fixc_q  <= '0;
    end else begin
      fixv_q <= 1'b0;
      if (clear) begin
        fail_q  <= 1'b0;
        total_q <= '0;
        max_q   <= '0;
      end else if (eval_en) begin
        case (kind)
          LANE_FIX: begin
            fixv_q  <= 1'b1;
            fixs_q  <= sector;
            fixc_q  <= cnt;
            total_q <= total_q + TOTAL_W'(cnt);
            if (cnt > max_q) max_q <= cnt;
          end
          LANE_FAIL: begin
            fail_q <= 1'b1;
            if (ucnt_q != {UCNT_W{1'b1}}) ucnt_q <= ucnt_q + UCNT_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign fail       = fail_q;
  assign total      = total_q;
  assign maxc       = max_q;
  assign ucnt       = ucnt_q;
  assign fix_valid  = fixv_q;
  assign fix_sector = fixs_q;
  assign fix_count  = fixc_q;

  // R6
  max_le_total_chk: assert property (@(posedge clk) disable iff (rst)
    TOTAL_W'(max_q) <= total_q);

  // R7
  ucnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (eval_en && kind == LANE_FAIL && ucnt_q != {UCNT_W{1'b1}})
      |=> (ucnt_q == $past(ucnt_q) + UCNT_W'(1)));

  // R7
  no_fix_after_fail_chk: assert property (@(posedge clk) disable iff (rst)
    fixv_q |-> !fail_q);

  // R9
  summary_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!eval_en && !clear) |=> ($stable(total_q) && $stable(fail_q) && $stable(max_q)));
endmodule

// File: rtl/ecc_status_scanner.sv
module ecc_status_scanner
  import ecc_scan_pkg::*;
#(
  parameter int LANES         = 4,
  parameter int LANE_W        = 8,
  parameter int CNT_W         = 5,
  parameter int MIN_PAGE_LOG2 = 11,
  parameter int SECT_LOG2     = 9,
  parameter int UCNT_W        = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   page_sel,
  input  logic         sect_1k,
  output logic         rd_en,
  output logic [1:0]   rd_addr,
  input  logic [31:0]  rd_data,
  output logic         busy,
  output logic         done,
  output logic         fail,
  output logic [8:0]   total_bits,
  output logic [4:0]   max_bits,
  output logic [7:0]   uncorr_count,
  output logic         fix_valid,
  output logic [3:0]   fix_sector,
  output logic [4:0]   fix_count
);
  localparam int WORD_W        = LANES * LANE_W;
  localparam int LANE_LOG2     = $clog2(LANES);
  localparam int MAX_SECT_LOG2 = MIN_PAGE_LOG2 + 2 - SECT_LOG2;
  localparam int MAX_WORDS     = (MAX_SECT_LOG2 > LANE_LOG2) ? (1 << (MAX_SECT_LOG2 - LANE_LOG2)) : 1;
  localparam int ADDR_W        = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int SECT_W        = ADDR_W + LANE_LOG2;
  localparam int TOTAL_W       = CNT_W + SECT_W;

  logic [1:0]            pcode;
  logic [ADDR_W:0]       n_words;
  logic [WORD_W-1:0]     word_q;
  logic                  word_zero;
  logic                  clear, load_word, eval_en, lane_fail;
  logic [LANE_LOG2-1:0]  lane;
  logic [ADDR_W-1:0]     word_idx;
  lane_kind_e            lane_kind [LANES];
  logic [CNT_W-1:0]      lane_cnt  [LANES];
  lane_kind_e            kind_sel;
  logic [CNT_W-1:0]      cnt_sel;

  // Page size code: 1x selects the largest page
  assign pcode = page_sel[1] ? 2'd2 : {1'b0, page_sel[0]};

  always_comb begin : word_count
    int sl;
    sl = MIN_PAGE_LOG2 - SECT_LOG2 + int'(pcode) - int'(sect_1k);
    if (sl > LANE_LOG2)
      n_words = (ADDR_W+1)'(1 << (sl - LANE_LOG2));
    else
      n_words = (ADDR_W+1)'(1);
  end

  assign word_zero = (rd_data == '0);

  always_ff @(posedge clk) begin
    if (rst)            word_q <= '0;
    else if (load_word) word_q <= rd_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ecc_lane_decode #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_dec (
      .lane_byte (word_q[g*LANE_W +: LANE_W]),
      .kind      (lane_kind[g]),
      .cnt       (lane_cnt[g])
    );
  end

  assign kind_sel  = lane_kind[lane];
  assign cnt_sel   = lane_cnt[lane];
  assign lane_fail = eval_en && (kind_sel == LANE_FAIL);

  ecc_scan_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_LOG2(LANE_LOG2)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .n_words   (n_words),
    .word_zero (word_zero),
    .lane_fail (lane_fail),
    .busy      (busy),
    .clear     (clear),
    .rd_en     (rd_en),
    .rd_addr   (word_idx),
    .load_word (load_word),
    .eval_en   (eval_en),
    .lane      (lane),
    .done      (done)
  );

  assign rd_addr = word_idx;

  ecc_scan_accum #(.CNT_W(CNT_W), .SECT_W(SECT_W), .TOTAL_W(TOTAL_W), .UCNT_W(UCNT_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .eval_en    (eval_en),
    .kind       (kind_sel),
    .cnt        (cnt_sel),
    .sector     ({word_idx, lane}),
    .fail       (fail),
    .total      (total_bits),
    .maxc       (max_bits),
    .ucnt       (uncorr_count),
    .fix_valid  (fix_valid),
    .fix_sector (fix_sector),
    .fix_count  (fix_count)
  );

  // R5
  fix_inside_scan_chk: assert property (@(posedge clk) disable iff (rst)
    fix_valid |-> busy);

  // R3
  zero_word_no_eval_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !eval_en && !load_word && $past(word_zero) && !$past(eval_en)) |-> !fix_valid);
endmodule

// File: tb/ecc_status_scanner_test.sv
module ecc_status_scanner_test;
  logic        clk = 1'b0;
  logic        rst, start, sect_1k;
  logic [1:0]  page_sel;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        busy, done, fail, fix_valid;
  logic [8:0]  total_bits;
  logic [4:0]  max_bits, fix_count;
  logic [7:0]  uncorr_count;
  logic [3:0]  fix_sector;

  always #2 clk = ~clk;

  ecc_status_scanner uut (
    .clk(clk), .rst(rst), .start(start), .page_sel(page_sel), .sect_1k(sect_1k),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .fail(fail), .total_bits(total_bits), .max_bits(max_bits), .uncorr_count(uncorr_count),
    .fix_valid(fix_valid), .fix_sector(fix_sector), .fix_count(fix_count));

  logic [31:0] mem [4];
  int nreads, maxaddr, nfix;
  int fsec [64];
  int fcnt [64];
  int checks = 0, errors = 0;

  int e_reads, e_total, e_max, e_nfix, e_ucnt;
  bit e_fail;
  int e_sec [64];
  int e_cnt [64];

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      nreads++;
      if (int'(rd_addr) > maxaddr) maxaddr = int'(rd_addr);
    end
  end

  always @(negedge clk) begin
    if (fix_valid && nfix < 64) begin
      fsec[nfix] = int'(fix_sector);
      fcnt[nfix] = int'(fix_count);
      nfix++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic compute_expect(input logic [1:0] ps, input logic s1k);
    int pc, sl, nw;
    bit stop;
    pc = ps[1] ? 2 : int'(ps[0]);
    sl = 2 + pc - int'(s1k);
    nw = (sl > 2) ? (1 << (sl - 2)) : 1;
    e_reads = 0; e_total = 0; e_max = 0; e_nfix = 0; e_fail = 0; stop = 0;
    for (int j = 0; j < nw && !stop; j++) begin
      e_reads++;
      if (mem[j] != 0) begin
        for (int i = 0; i < 4 && !stop; i++) begin
          logic [7:0] b;
          b = mem[j][8*i +: 8];
          if (b != 8'h00) begin
            if (b[1:0] == 2'b01) begin
              e_sec[e_nfix] = 4*j + i;
              e_cnt[e_nfix] = int'(b[6:2]);
              e_nfix++;
              e_total += int'(b[6:2]);
              if (int'(b[6:2]) > e_max) e_max = int'(b[6:2]);
            end else begin
              e_fail = 1;
              if (e_ucnt < 255) e_ucnt++;
              stop = 1;
            end
          end
        end
      end
    end
  endtask

  task automatic run_scan(input logic [1:0] ps, input logic s1k, input bit poke);
    int waited;
    compute_expect(ps, s1k);
    nreads = 0; nfix = 0; maxaddr = 0;
    @(negedge clk);
    page_sel = ps; sect_1k = s1k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      page_sel = 2'b11; sect_1k = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, "R9 done reached", int'(done), 1);
    check(fail == e_fail, "R7 fail", int'(fail), int'(e_fail));
    check(int'(total_bits) == e_total, "R6 total", int'(total_bits), e_total);
    check(int'(max_bits) == e_max, "R6 max", int'(max_bits), e_max);
    check(int'(uncorr_count) == e_ucnt, "R7 uncorr count", int'(uncorr_count), e_ucnt);
    check(nreads == e_reads, "R2 reads", nreads, e_reads);
    check(maxaddr == e_reads - 1, "R2 last addr", maxaddr, e_reads - 1);
    check(nfix == e_nfix, "R5 fix count", nfix, e_nfix);
    for (int k = 0; k < nfix && k < e_nfix; k++) begin
      check(fsec[k] == e_sec[k], "R4 sector", fsec[k], e_sec[k]);
      check(fcnt[k] == e_cnt[k], "R5 count", fcnt[k], e_cnt[k]);
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R9 idle after done", int'(busy), 0);
    check(int'(total_bits) == e_total && fail == e_fail && int'(max_bits) == e_max,
          "R9 hold", int'(total_bits), e_total);
    check(nfix == e_nfix && nreads == e_reads, "R9 no activity after done", nfix, e_nfix);
  endtask

  function automatic logic [7:0] rand_byte();
    int r;
    logic [7:0] b;
    r = int'($urandom_range(99));
    b = 8'($urandom);
    if (r < 40) return 8'h00;
    if (r < 85) return {b[7:2], 2'b01};
    if (r < 90) return (b[7:2] == 0) ? 8'h80 : {b[7:2], 2'b00};
    return {b[7:2], (r < 95) ? 2'b10 : 2'b11};
  endfunction

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; page_sel = 2'b00; sect_1k = 1'b0; rd_data = '0;
    e_ucnt = 0; nreads = 0; nfix = 0; maxaddr = 0;
    for (int i = 0; i < 4; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !fail && !fix_valid && !rd_en, "R1 control outputs", int'(busy), 0);
    check(total_bits == 0 && max_bits == 0, "R1 summary zero", int'(total_bits), 0);
    check(uncorr_count == 0, "R1 uncorr zero", int'(uncorr_count), 0);

    // R3 all-zero page, 8K / 512 -> 4 words read, nothing reported
    run_scan(2'b10, 1'b0, 0);

    // R5 R6 R4 all correctable, varying counts and lanes
    mem[0] = 32'h0D_00_15_05; mem[1] = 32'h00_00_00_00;
    mem[2] = 32'h7D_01_00_81; mem[3] = 32'h00_29_00_00;
    run_scan(2'b11, 1'b0, 0);

    // R8 zero bytes inside non-zero word; R10 bit 7 excluded from count
    mem[0] = 32'h00_FD_00_00;
    run_scan(2'b00, 1'b0, 0);

    // R7 unrepairable in middle of word 1 of a 4K/512 page stops the scan
    mem[0] = 32'h00_00_09_11; mem[1] = 32'h05_03_00_21; mem[2] = 32'h00_00_00_45;
    run_scan(2'b01, 1'b0, 0);

    // R10 verdict 00 with non-zero count bits is unrepairable
    mem[0] = 32'h00_00_0C_00;
    run_scan(2'b00, 1'b1, 0);

    // R2 2K page with 1K sectors -> single word; 8K/1K -> 2 words
    mem[0] = 32'h05_05_05_05; mem[1] = 32'h09_09_09_09;
    run_scan(2'b00, 1'b1, 0);
    run_scan(2'b10, 1'b1, 0);

    // R9 start while busy ignored (poke asks for 4 words; 1 expected)
    mem[0] = 32'h11_21_31_41;
    run_scan(2'b00, 1'b0, 1);

    // Constrained random scans
    for (int n = 0; n < 60; n++) begin
      for (int w = 0; w < 4; w++) begin
        if ($urandom_range(99) < 20) mem[w] = '0;
        else mem[w] = {rand_byte(), rand_byte(), rand_byte(), rand_byte()};
      end
      run_scan(2'($urandom_range(3)), 1'($urandom_range(1)), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule